// File: doc/BRIEF.md
# Checked Little-Endian Load/Store Unit

This unit sits between the execute stage of a small 32-bit core and a byte-addressable data memory of `MEM_SIZE` bytes, organised as 32-bit words. For each request it adds a base register value to a sign-extended 16-bit displacement to form a byte address. It checks that address against the memory window and against the alignment rule of the access width, then drives a word-wide synchronous memory port with byte-lane enables.

A request that breaks any rule, or that carries an opcode the unit does not handle, raises `abort` combinationally in the request cycle. An aborted request leaves memory untouched. Load results come back one cycle after the request, once the synchronous memory has answered. The byte that was addressed is picked from its little-endian lane and then sign- or zero-extended.

Top module: `ldst_guard_unit`

## Requirements
- R1: The byte address is `req_base` plus `req_offset` sign-extended to 32 bits, with wrap-around modulo 2^32. `mem_addr` is that address with its two low bits dropped.
- R2: Opcode values: 0x20 is signed byte load, 0x23 is word load, 0x24 is unsigned byte load, 0x28 is byte store and 0x2b is word store. Any other opcode with `req_valid` high raises `abort`.
- R3: An access is legal only if its unsigned byte address lies in [1, MEM_SIZE). Address 0, addresses at or above `MEM_SIZE`, and wrapped negative addresses all raise `abort`.
- R4: Word loads and word stores need the two low address bits to be 00, and otherwise raise `abort`. Byte loads and byte stores are legal at any in-range address.
- R5: `abort` is asserted in the same cycle as the request. While it is high, `mem_we` and `mem_re` stay low, and `ld_valid` stays low in the next cycle.
- R6: Lanes are little-endian. The byte at an address whose two low bits are k sits on bits 8k+7 down to 8k of the memory word.
- R7: A legal word load drives `mem_re` in the request cycle. It returns the whole memory word on `ld_data` with `ld_valid` high in the following cycle.
- R8: A signed byte load (0x20) sign-extends the addressed byte to 32 bits. An unsigned byte load (0x24) zero-extends it.
- R9: A legal byte store drives a one-hot `mem_be` with bit k set, where k is the two low address bits. It carries the low byte of `req_wdata` on lane k, so only that byte of memory changes. A legal word store drives `mem_be` = 4'b1111 and the full `req_wdata`.
- R10: After reset, and whenever `req_valid` is low, `abort`, `mem_we` and `mem_re` are low. `ld_valid` is low and `ld_data` is zero in every cycle that does not follow a legal load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_opcode | input | 6 | Operation code of the request |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store data (the low byte is used for byte stores) |
| abort | output | 1 | Request is illegal and was not performed |
| mem_addr | output | WA_W | Word address to memory |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_be | output | 4 | Byte-lane write enables |
| mem_wdata | output | 32 | Write data, placed on lanes |
| mem_rdata | input | 32 | Read data from memory, valid the cycle after `mem_re` |
| ld_valid | output | 1 | `ld_data` holds a load result |
| ld_data | output | 32 | Extended load result |

## Verification
The bench aims at the edges of the address window: address 0 and the first byte after it, the last word and the last byte below `MEM_SIZE`, the first address beyond it, and a negative displacement that wraps past zero. A design with an off-by-one bound would either write outside memory or refuse the last byte. Word accesses are sent to each misaligned lane, so an alignment check that is missing or taken from the wrong bits shows up as a memory write that should not happen. Byte stores and byte loads are placed on all four lanes with bytes whose top bit is set. A swapped lane order, a wrong extension or a store that spills onto neighbouring lanes then appears as a wrong read-back from a shadow model of memory. Unknown opcodes, and cycles with no request, check that nothing leaks onto the memory strobes.

// File: rtl/ldst_pkg.sv
`timescale 1ns/1ps
// Package: shared opcode values and the decoded-operation record for the
// load/store unit. Assumes 6-bit primary opcodes.
package ldst_pkg;

    localparam logic [5:0] OPC_LDB  = 6'h20;  // signed byte load
    localparam logic [5:0] OPC_LDW  = 6'h23;  // word load
    localparam logic [5:0] OPC_LDBU = 6'h24;  // unsigned byte load
    localparam logic [5:0] OPC_STB  = 6'h28;  // byte store
    localparam logic [5:0] OPC_STW  = 6'h2b;  // word store

    typedef struct packed {
        logic known;      // opcode is one the unit handles
        logic is_load;
        logic is_store;
        logic is_word;    // full-word access, otherwise a single byte
        logic is_signed;  // sign-extend a byte load
    } op_kind_t;

    // Map an opcode to its operation attributes.
    function automatic op_kind_t decode_op(input logic [5:0] opc);
        op_kind_t k;
        k = '0;
        unique case (opc)
            OPC_LDB:  begin k.known = 1'b1; k.is_load  = 1'b1; k.is_signed = 1'b1; end
            OPC_LDW:  begin k.known = 1'b1; k.is_load  = 1'b1; k.is_word   = 1'b1; end
            OPC_LDBU: begin k.known = 1'b1; k.is_load  = 1'b1; end
            OPC_STB:  begin k.known = 1'b1; k.is_store = 1'b1; end
            OPC_STW:  begin k.known = 1'b1; k.is_store = 1'b1; k.is_word   = 1'b1; end
            default:  k = '0;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/ldst_addr_check.sv
`timescale 1ns/1ps
// Module: ldst_addr_check
// Forms the byte address from base plus sign-extended displacement and
// decides whether it may be used. Assumes the legal window is [1, MEM_SIZE)
// and that word accesses must sit on a lane-0 boundary. Purely combinational.
module ldst_addr_check #(
    parameter int MEM_SIZE = 1024,
    parameter int ADDR_W   = 32,
    parameter int OFF_W    = 16,
    parameter int LANE_W   = 2,
    parameter int BA_W     = $clog2(MEM_SIZE),
    localparam int WA_W    = BA_W - LANE_W
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    input  logic              is_word,
    output logic [WA_W-1:0]   word_addr,
    output logic [LANE_W-1:0] lane,
    output logic              legal
);
    logic [ADDR_W-1:0] ea;
    logic              in_range;
    logic              aligned;

    // Effective address: sign-extend the displacement and add.
    always_comb begin
        ea = base + {{(ADDR_W-OFF_W){offset[OFF_W-1]}}, offset};
    end

    // Window and alignment tests, then the combined verdict.
    always_comb begin
        in_range  = (ea != '0) && (ea < ADDR_W'(MEM_SIZE));
        aligned   = !is_word || (ea[LANE_W-1:0] == '0);
        legal     = in_range && aligned;
        word_addr = ea[BA_W-1:LANE_W];
        lane      = ea[LANE_W-1:0];
    end

endmodule

// File: rtl/ldst_store_fmt.sv
`timescale 1ns/1ps
// Module: ldst_store_fmt
// Places store data on memory lanes and builds the byte enables.
// Word stores use every lane. Byte stores repeat the low byte on all lanes
// and enable only the addressed lane (little-endian lane numbering).
module ldst_store_fmt #(
    parameter int DATA_W    = 32,
    localparam int NLANES   = DATA_W / 8,
    localparam int LANE_W   = $clog2(NLANES)
) (
    input  logic [DATA_W-1:0] wdata,
    input  logic [LANE_W-1:0] lane,
    input  logic              is_word,
    output logic [NLANES-1:0] be,
    output logic [DATA_W-1:0] lane_data
);
    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        // Enable and data for lane g.
        always_comb begin
            be[g]             = is_word || (lane == LANE_W'(g));
            lane_data[g*8 +: 8] = is_word ? wdata[g*8 +: 8] : wdata[7:0];
        end
    end

endmodule

// File: rtl/ldst_load_ext.sv
`timescale 1ns/1ps
// Module: ldst_load_ext
// Turns a returned memory word into the load result: the whole word, or the
// byte of the selected lane extended by sign or by zero. Combinational.
module ldst_load_ext #(
    parameter int DATA_W    = 32,
    localparam int NLANES   = DATA_W / 8,
    localparam int LANE_W   = $clog2(NLANES)
) (
    input  logic [DATA_W-1:0] rdata,
    input  logic [LANE_W-1:0] lane,
    input  logic              is_word,
    input  logic              is_signed,
    output logic [DATA_W-1:0] result
);
    logic [7:0] bytes [NLANES];
    logic [7:0] pick;

    for (genvar g = 0; g < NLANES; g++) begin : g_split
        // Split the word into lanes, lane 0 lowest.
        assign bytes[g] = rdata[g*8 +: 8];
    end

    // Select the lane and extend it.
    always_comb begin
        pick = bytes[lane];
        if (is_word) begin
            result = rdata;
        end else if (is_signed) begin
            result = {{(DATA_W-8){pick[7]}}, pick};
        end else begin
            result = {{(DATA_W-8){1'b0}}, pick};
        end
    end

endmodule

// File: rtl/ldst_guard_unit.sv
`timescale 1ns/1ps
// Module: ldst_guard_unit (top)
// Checked load/store unit for a little-endian word memory. Decodes the
// opcode, checks the address, and either drives the memory port or raises
// abort in the same cycle. Assumes memory read data arrives one cycle after
// mem_re. The load result is registered alongside that latency.
module ldst_guard_unit #(
    parameter int MEM_SIZE  = 1024,
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int OFF_W     = 16,
    localparam int NLANES   = DATA_W / 8,
    localparam int LANE_W   = $clog2(NLANES),
    localparam int BA_W     = $clog2(MEM_SIZE),
    localparam int WA_W     = BA_W - LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [5:0]        req_opcode,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              abort,
    output logic [WA_W-1:0]   mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [NLANES-1:0] mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              ld_valid,
    output logic [DATA_W-1:0] ld_data
);
    import ldst_pkg::*;

    op_kind_t           kind;
    logic               legal;
    logic [LANE_W-1:0]  lane;
    logic [NLANES-1:0]  st_be;
    logic [DATA_W-1:0]  st_data;
    logic [DATA_W-1:0]  ext_data;

    logic               ld_pend_q;
    logic [LANE_W-1:0]  lane_q;
    logic               word_q;
    logic               sign_q;

    // Decode the requested operation.
    always_comb begin
        kind = decode_op(req_opcode);
    end

    ldst_addr_check #(
        .MEM_SIZE (MEM_SIZE),
        .ADDR_W   (ADDR_W),
        .OFF_W    (OFF_W),
        .LANE_W   (LANE_W),
        .BA_W     (BA_W)
    ) u_addr (
        .base      (req_base),
        .offset    (req_offset),
        .is_word   (kind.is_word),
        .word_addr (mem_addr),
        .lane      (lane),
        .legal     (legal)
    );

    ldst_store_fmt #(
        .DATA_W (DATA_W)
    ) u_store (
        .wdata     (req_wdata),
        .lane      (lane),
        .is_word   (kind.is_word),
        .be        (st_be),
        .lane_data (st_data)
    );

    // Abort and memory strobes; a failed check suppresses every strobe.
    always_comb begin
        abort     = req_valid && !(kind.known && legal);
        mem_re    = req_valid && kind.is_load  && legal;
        mem_we    = req_valid && kind.is_store && legal;
        mem_be    = mem_we ? st_be : '0;
        mem_wdata = st_data;
    end

    // Remember how to shape the load result while memory answers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_pend_q <= 1'b0;
            lane_q    <= '0;
            word_q    <= 1'b0;
            sign_q    <= 1'b0;
        end else begin
            ld_pend_q <= mem_re;
            if (mem_re) begin
                lane_q <= lane;
                word_q <= kind.is_word;
                sign_q <= kind.is_signed;
            end
        end
    end

    ldst_load_ext #(
        .DATA_W (DATA_W)
    ) u_load (
        .rdata     (mem_rdata),
        .lane      (lane_q),
        .is_word   (word_q),
        .is_signed (sign_q),
        .result    (ext_data)
    );

    // Present the result only in the cycle after a legal load.
    always_comb begin
        ld_valid = ld_pend_q;
        ld_data  = ld_pend_q ? ext_data : '0;
    end

endmodule

// File: rtl/ldst_guard_chk.sv
`timescale 1ns/1ps
// Module: ldst_guard_chk
// Property checker for ldst_guard_unit, attached by bind. Recomputes the
// byte address from the request ports only, to relate requests to strobes.
module ldst_guard_chk #(
    parameter int MEM_SIZE = 1024
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [5:0]  req_opcode,
    input logic [31:0] req_base,
    input logic [15:0] req_offset,
    input logic [31:0] req_wdata,
    input logic        abort,
    input logic        mem_re,
    input logic        mem_we,
    input logic [3:0]  mem_be,
    input logic [31:0] mem_wdata,
    input logic        ld_valid
);
    logic [31:0] c_ea;
    logic        c_known;
    logic        c_wordop;

    // Reference address and opcode class from the ports.
    always_comb begin
        c_ea     = req_base + {{16{req_offset[15]}}, req_offset};
        c_known  = (req_opcode == 6'h20) || (req_opcode == 6'h23) || (req_opcode == 6'h24)
                || (req_opcode == 6'h28) || (req_opcode == 6'h2b);
        c_wordop = (req_opcode == 6'h23) || (req_opcode == 6'h2b);
    end

    p_unknown_op_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !c_known |-> abort);
    p_zero_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (c_ea == 32'd0) |-> abort);
    p_upper_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (c_ea >= 32'(MEM_SIZE)) |-> abort);
    p_word_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && c_wordop && (c_ea[1:0] != 2'b00) |-> abort);
    p_abort_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> !mem_we && !mem_re);
    p_abort_noload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !ld_valid);
    p_byte_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && (req_opcode == 6'h28) |-> mem_be[c_ea[1:0]]);
    p_load_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(mem_re));
    p_byte_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && (req_opcode == 6'h28) |-> ($countones(mem_be) == 1)
            && (mem_wdata[8*c_ea[1:0] +: 8] == req_wdata[7:0]));
    p_word_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && (req_opcode == 6'h2b) |-> (mem_be == 4'hF) && (mem_wdata == req_wdata));
    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !abort && !mem_we && !mem_re);

endmodule

bind ldst_guard_unit ldst_guard_chk #(.MEM_SIZE(MEM_SIZE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_opcode (req_opcode),
    .req_base   (req_base),
    .req_offset (req_offset),
    .req_wdata  (req_wdata),
    .abort      (abort),
    .mem_re     (mem_re),
    .mem_we     (mem_we),
    .mem_be     (mem_be),
    .mem_wdata  (mem_wdata),
    .ld_valid   (ld_valid)
);

// File: tb/tb_ldst_guard_unit.sv
`timescale 1ns/1ps
// Bench for ldst_guard_unit: directed corners plus seeded random requests,
// checked against a byte-wide shadow of memory kept by the bench.
module tb_ldst_guard_unit;
    localparam int MSZ   = 1024;
    localparam int WORDS = MSZ / 4;
    localparam int WA    = $clog2(MSZ) - 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [5:0]  req_opcode = '0;
    logic [31:0] req_base = '0;
    logic [15:0] req_offset = '0;
    logic [31:0] req_wdata = '0;
    logic        abort;
    logic [WA-1:0] mem_addr;
    logic        mem_re, mem_we;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        ld_valid;
    logic [31:0] ld_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Test memory with a bench preload port.
    logic [31:0] tmem [WORDS];
    logic        pre_we = 1'b0;
    logic [WA-1:0] pre_a = '0;
    logic [31:0] pre_d = '0;
    logic [7:0]  shadow [MSZ];

    always #2.5 clk = ~clk;

    ldst_guard_unit #(.MEM_SIZE(MSZ)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_opcode(req_opcode),
        .req_base(req_base), .req_offset(req_offset), .req_wdata(req_wdata),
        .abort(abort), .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .ld_valid(ld_valid), .ld_data(ld_data)
    );

    // Synchronous memory: byte-enabled writes, registered reads.
    always_ff @(posedge clk) begin
        if (pre_we) tmem[pre_a] <= pre_d;
        else if (mem_we) begin
            for (int b = 0; b < 4; b++)
                if (mem_be[b]) tmem[mem_addr][b*8 +: 8] <= mem_wdata[b*8 +: 8];
        end
        if (mem_re) mem_rdata <= tmem[mem_addr];
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit op_known(input logic [5:0] op);
        return op == 6'h20 || op == 6'h23 || op == 6'h24 || op == 6'h28 || op == 6'h2b;
    endfunction

    function automatic bit op_legal(input logic [5:0] op, input logic [31:0] ea);
        bit w;
        w = (op == 6'h23) || (op == 6'h2b);
        if (!op_known(op)) return 1'b0;
        if (ea == 32'd0 || ea >= 32'(MSZ)) return 1'b0;
        if (w && ea[1:0] != 2'b00) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [31:0] exp_load(input logic [5:0] op, input logic [31:0] ea);
        logic [7:0] b;
        if (op == 6'h23)
            return {shadow[ea+3], shadow[ea+2], shadow[ea+1], shadow[ea]};
        b = shadow[ea];
        if (op == 6'h20) return {{24{b[7]}}, b};
        return {24'd0, b};
    endfunction

    // One request: check the strobes in its cycle, the load result in the next.
    task automatic do_op(input string tag, input logic [5:0] op, input logic [31:0] base,
                         input logic [15:0] off, input logic [31:0] wd);
        logic [31:0] ea;
        bit lg, ld, st;
        logic [31:0] exp_ld;
        ea = base + {{16{off[15]}}, off};
        lg = op_legal(op, ea);
        ld = lg && (op == 6'h20 || op == 6'h23 || op == 6'h24);
        st = lg && (op == 6'h28 || op == 6'h2b);
        exp_ld = ld ? exp_load(op, ea) : 32'd0;
        @(negedge clk);
        req_valid = 1'b1; req_opcode = op; req_base = base; req_offset = off; req_wdata = wd;
        #1;
        chk({tag, " R5 abort"}, {31'd0, abort}, {31'd0, !lg});
        chk({tag, " R5 we"}, {31'd0, mem_we}, {31'd0, st});
        chk({tag, " R7 re"}, {31'd0, mem_re}, {31'd0, ld});
        if (lg) chk({tag, " R1 addr"}, 32'(mem_addr), 32'(ea[$clog2(MSZ)-1:2]));
        if (st && op == 6'h28) begin
            chk({tag, " R9 be"}, {28'd0, mem_be}, 32'(4'b0001 << ea[1:0]));
            chk({tag, " R6 lane"}, {24'd0, mem_wdata[8*ea[1:0] +: 8]}, {24'd0, wd[7:0]});
        end
        if (st && op == 6'h2b) begin
            chk({tag, " R9 be"}, {28'd0, mem_be}, 32'hF);
            chk({tag, " R9 wdata"}, mem_wdata, wd);
        end
        @(posedge clk);
        if (st) begin
            if (op == 6'h2b) for (int b = 0; b < 4; b++) shadow[ea + b] = wd[b*8 +: 8];
            else shadow[ea] = wd[7:0];
        end
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk({tag, " R10 ldv"}, {31'd0, ld_valid}, {31'd0, ld});
        chk({tag, " R8 lddata"}, ld_data, exp_ld);
    endtask

    initial begin
        logic [31:0] w;
        // Preload memory and shadow with a pattern that has high bits set.
        for (int i = 0; i < MSZ; i++) shadow[i] = 8'((i * 37) ^ (i >> 3) ^ 8'h96);
        for (int i = 0; i < WORDS; i++) begin
            @(negedge clk);
            pre_we = 1'b1; pre_a = WA'(i);
            pre_d = {shadow[4*i+3], shadow[4*i+2], shadow[4*i+1], shadow[4*i]};
        end
        @(negedge clk); pre_we = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: idle after reset
        chk("R10 reset ldv", {31'd0, ld_valid}, 32'd0);
        chk("R10 reset lddata", ld_data, 32'd0);
        chk("R10 idle abort", {31'd0, abort}, 32'd0);
        chk("R10 idle strobes", {30'd0, mem_we, mem_re}, 32'd0);

        do_op("R7 lw4", 6'h23, 32'd4, 16'd0, 0);
        do_op("R3 lw0", 6'h23, 32'd0, 16'd0, 0);
        do_op("R3 lb0", 6'h20, 32'd0, 16'd0, 0);
        do_op("R3 lb1", 6'h20, 32'd1, 16'd0, 0);
        do_op("R8 lbu1", 6'h24, 32'd0, 16'd1, 0);
        do_op("R4 lw2", 6'h23, 32'd2, 16'd0, 0);
        do_op("R4 sw3", 6'h2b, 32'd3, 16'd0, 32'hDEADBEEF);
        do_op("R4 sw1", 6'h2b, 32'd1, 16'd0, 32'hDEADBEEF);
        do_op("R4 lw6_chk", 6'h23, 32'd0, 16'd4, 0);
        do_op("R3 swtop", 6'h2b, 32'(MSZ-4), 16'd0, 32'h8172_63F4);
        do_op("R3 lwtop", 6'h23, 32'(MSZ), 16'hFFFC, 0);
        do_op("R3 sblast", 6'h28, 32'(MSZ-1), 16'd0, 32'h0000_00C7);
        do_op("R8 lblast", 6'h20, 32'(MSZ-1), 16'd0, 0);
        do_op("R3 lbend", 6'h20, 32'(MSZ), 16'd0, 0);
        do_op("R3 wrapneg", 6'h24, 32'd0, 16'hFFFF, 0);
        do_op("R1 negoff", 6'h23, 32'd100, 16'hFFFC, 0);
        do_op("R2 unknown", 6'h21, 32'd8, 16'd0, 32'h1234_5678);
        do_op("R2 unkstore", 6'h29, 32'd8, 16'd0, 32'h1234_5678);
        do_op("R9 sblane2", 6'h28, 32'd64, 16'd2, 32'h1234_56F0);
        do_op("R9 lwlane2", 6'h23, 32'd64, 16'd0, 0);
        for (int k = 0; k < 4; k++) begin
            do_op("R6 sbk", 6'h28, 32'(200 + k), 16'd0, 32'(8'h80 + k));
            do_op("R6 lbk", 6'h20, 32'(200 + k), 16'd0, 0);
            do_op("R8 lbuk", 6'h24, 32'(200 + k), 16'd0, 0);
        end
        do_op("R6 lwk", 6'h23, 32'd200, 16'd0, 0);

        // Seeded random traffic near and beyond the window.
        void'($urandom(32'h5EED_1234));
        for (int n = 0; n < 600; n++) begin
            logic [5:0] op;
            logic [31:0] ea, base;
            logic [15:0] off;
            int r;
            r = $urandom_range(0, 19);
            case (r % 6)
                0: op = 6'h20; 1: op = 6'h23; 2: op = 6'h24;
                3: op = 6'h28; 4: op = 6'h2b;
                default: op = (r > 15) ? 6'(($urandom_range(0, 63))) : 6'h23;
            endcase
            if (r == 0) ea = 32'($urandom_range(0, 3));
            else if (r == 1) ea = 32'(MSZ - 4 + $urandom_range(0, 7));
            else if (r == 2) ea = $urandom();
            else ea = 32'($urandom_range(0, MSZ - 1));
            off  = 16'($urandom());
            base = ea - {{16{off[15]}}, off};
            w    = $urandom();
            do_op("R1 rand", op, base, off, w);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule